// File: doc/BRIEF.md
# Pulse-Swallow PLL Feedback Divider

This block is the digital model of the programmable dividers of a frequency synthesizer. On the fast clock it divides by a total ratio N using a dual-modulus prescaler that divides by 8 or by 9. A 3-bit swallow counter and a 10-bit program counter steer the prescaler. The divider emits one single-cycle feedback pulse every N fast-clock cycles. A separate 10-bit divider runs on the crystal-rate clock and emits the reference pulse every R cycles of that clock.

The programmed N is a 13-bit word. Its low 3 bits are the swallow count A and its high 10 bits are the program count M. Each output cycle is made of M prescaler cycles. The first A of them last 9 clocks and the rest last 8, so N = 8·M + A. New N and R words are taken only at the end of the output cycle in progress. After reset the feedback divider runs one cycle at a ratio chosen by a strap pin. The phase detector, charge pump, oscillator and loop filter are outside this block.

Top module: `pll_fb_divider`

## Requirements
- R1: The fast-clock distance between successive `fb_pulse` assertions equals the active ratio N = 8·M + A, where A = `n_cfg[2:0]` and M = `n_cfg[12:3]`.
- R2: Within one output cycle the prescaler divides by 9 for the first A prescaler cycles and by 8 for the remaining M − A. The measured period therefore includes A extra clocks over 8·M for every A from 0 to 7.
- R3: Legal ratios run from 56 to 8191. A programmed value below 56 (M below 7) is treated as 56.
- R4: A new `n_cfg` value has no effect on the output cycle in progress. It becomes the ratio from the next `fb_pulse` onward, so no shortened period appears.
- R5: `fb_pulse` is high for exactly one fast-clock cycle per output cycle. It is low during reset.
- R6: The first output cycle after reset uses a strap-selected ratio. With `strap_alt` = 0 it is A = 1 and M = 0x1D5 (N = 3753). With `strap_alt` = 1 it is A = 7 and M = 0x1CD (N = 3695).
- R7: The crystal-clock distance between successive `ref_pulse` assertions equals `r_cfg` for values 1 to 1023. `ref_pulse` is low during reset.
- R8: An `r_cfg` value of 0 acts as divide-by-1, so `ref_pulse` stays high on every crystal clock.
- R9: A new `r_cfg` value takes effect only after the next `ref_pulse`. The reference period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast clock to be divided by N |
| clk_ref | input | 1 | Crystal-rate clock to be divided by R |
| rst_n | input | 1 | Asynchronous active-low reset for both dividers |
| strap_alt | input | 1 | Selects which default ratio applies after reset |
| n_cfg | input | 13 | Feedback ratio: [2:0] swallow count, [12:3] program count |
| r_cfg | input | 10 | Reference ratio; 0 means 1 |
| fb_pulse | output | 1 | Single-cycle feedback pulse on `clk_vco` |
| ref_pulse | output | 1 | Single-cycle reference pulse on `clk_ref` |

## Verification
A feedback pulse is registered. It shows up one edge after the last prescaler cycle of an output cycle ends, which puts it exactly N edges after the previous pulse. A reference pulse shows up exactly R crystal edges after the previous one. The bench counts rising edges and samples the outputs on the falling edge. A new ratio is written on the falling edge where a pulse has just been seen. The next period is then expected to have the old length and only the one after it the new length. The first pulse after reset release is expected on the strap ratio's edge.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
    localparam int unsigned SWALLOW_W_DEF = 3;
    localparam int unsigned PROGRAM_W_DEF = 10;
    localparam int unsigned REF_W_DEF     = 10;
    localparam int unsigned DEF0_A        = 1;
    localparam int unsigned DEF0_M        = 469;
    localparam int unsigned DEF1_A        = 7;
    localparam int unsigned DEF1_M        = 461;
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int unsigned SW_W = swdiv_pkg::SWALLOW_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_high,
    output logic tc
);
    localparam int unsigned P  = 1 << SW_W;
    localparam int unsigned CW = SW_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        st_d = st_q;
        last = sel_high ? CW'(P) : CW'(P - 1);
        tc   = (st_q.cnt == last);
        if (tc) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(P));

    assert_long_only_when_swallowing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(P)) |-> sel_high);
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
    parameter int unsigned SW_W = swdiv_pkg::SWALLOW_W_DEF,
    parameter int unsigned PG_W = swdiv_pkg::PROGRAM_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_alt,
    input  logic [SW_W+PG_W-1:0] n_cfg,
    input  logic                 pre_tc,
    output logic                 sel_high,
    output logic                 fb_pulse
);
    localparam int unsigned NW    = SW_W + PG_W;
    localparam int unsigned P     = 1 << SW_W;
    localparam int unsigned MIN_N = P * (P - 1);

    typedef struct packed {
        logic [SW_W-1:0] a_rem;
        logic [PG_W-1:0] m_rem;
        logic            fb;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [NW-1:0] n_eff;

    always_comb begin
        st_d     = st_q;
        n_eff    = (n_cfg < NW'(MIN_N)) ? NW'(MIN_N) : n_cfg;
        sel_high = (st_q.a_rem != '0);
        st_d.fb  = 1'b0;
        if (pre_tc) begin
            if (st_q.m_rem == PG_W'(1)) begin
                st_d.fb    = 1'b1;
                st_d.a_rem = n_eff[SW_W-1:0];
                st_d.m_rem = n_eff[NW-1:SW_W];
            end else begin
                st_d.m_rem = st_q.m_rem - 1'b1;
                if (st_q.a_rem != '0) begin
                    st_d.a_rem = st_q.a_rem - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a_rem <= strap_alt ? SW_W'(swdiv_pkg::DEF1_A) : SW_W'(swdiv_pkg::DEF0_A);
            st_q.m_rem <= strap_alt ? PG_W'(swdiv_pkg::DEF1_M) : PG_W'(swdiv_pkg::DEF0_M);
            st_q.fb    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_pulse = st_q.fb;

    assert_prog_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.m_rem != '0);

    assert_swallow_within_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        PG_W'(st_q.a_rem) <= st_q.m_rem);

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tc |=> ($stable(st_q.m_rem) && $stable(st_q.a_rem)));

    assert_fb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int unsigned R_W = swdiv_pkg::REF_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_cfg,
    output logic           ref_pulse
);
    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic [R_W-1:0] lim;
        logic           pls;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic tc;

    always_comb begin
        st_d     = st_q;
        tc       = (st_q.cnt == st_q.lim - 1'b1);
        st_d.pls = tc;
        if (tc) begin
            st_d.cnt = '0;
            st_d.lim = (r_cfg == '0) ? R_W'(1) : r_cfg;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lim <= R_W'(1);
            st_q.pls <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_pulse = st_q.pls;

    assert_ref_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.lim);

    assert_ref_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && st_q.lim > R_W'(1)) |=> !ref_pulse);

    assert_ref_lim_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lim != '0);
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
    parameter int unsigned SW_W = swdiv_pkg::SWALLOW_W_DEF,
    parameter int unsigned PG_W = swdiv_pkg::PROGRAM_W_DEF,
    parameter int unsigned R_W  = swdiv_pkg::REF_W_DEF
) (
    input  logic                 clk_vco,
    input  logic                 clk_ref,
    input  logic                 rst_n,
    input  logic                 strap_alt,
    input  logic [SW_W+PG_W-1:0] n_cfg,
    input  logic [R_W-1:0]       r_cfg,
    output logic                 fb_pulse,
    output logic                 ref_pulse
);
    logic pre_tc;
    logic sel_high;

    dm_prescaler #(.SW_W(SW_W)) i_pre (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .sel_high (sel_high),
        .tc       (pre_tc)
    );

    swallow_ctrl #(.SW_W(SW_W), .PG_W(PG_W)) i_ctl (
        .clk       (clk_vco),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .n_cfg     (n_cfg),
        .pre_tc    (pre_tc),
        .sel_high  (sel_high),
        .fb_pulse  (fb_pulse)
    );

    ref_divider #(.R_W(R_W)) i_ref (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .r_cfg     (r_cfg),
        .ref_pulse (ref_pulse)
    );
endmodule

// File: tb/test_pll_fb_divider.sv
module test_pll_fb_divider;
    logic        clk_vco = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic [12:0] n_cfg = 13'd200;
    logic [9:0]  r_cfg = 10'd0;
    logic        fb_pulse;
    logic        ref_pulse;

    int n_checks = 0;
    int n_fail = 0;
    int cur_n;
    int cur_r;
    int cycles = 0;

    pll_fb_divider i_pll_fb_divider (
        .clk_vco   (clk_vco),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .n_cfg     (n_cfg),
        .r_cfg     (r_cfg),
        .fb_pulse  (fb_pulse),
        .ref_pulse (ref_pulse)
    );

    always #10 clk_vco = ~clk_vco;
    initial begin
        #5;
        forever #10 clk_ref = ~clk_ref;
    end

    function automatic int exp_ratio(input int n);
        int m, a;
        m = n >> 3;
        a = n & 7;
        if (m < 7) return 56;
        return 9 * a + 8 * (m - a);
    endfunction

    function automatic int exp_ref(input int r);
        return (r == 0) ? 1 : r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fb(output int t);
        t = 0;
        do begin
            @(posedge clk_vco);
            t++;
            @(negedge clk_vco);
        end while (!fb_pulse && t < 9000);
    endtask

    task automatic wait_ref(output int t);
        t = 0;
        do begin
            @(posedge clk_ref);
            t++;
            @(negedge clk_ref);
        end while (!ref_pulse && t < 2000);
    endtask

    task automatic program_n(input string req, input int n);
        int t;
        n_cfg = 13'(n);
        wait_fb(t);
        check("R4 old ratio kept", t, exp_ratio(cur_n));
        cur_n = n;
        wait_fb(t);
        check(req, t, exp_ratio(n));
    endtask

    task automatic program_r(input string req, input int r);
        int t;
        r_cfg = 10'(r);
        wait_ref(t);
        check("R9 old ratio kept", t, exp_ref(cur_r));
        cur_r = r;
        wait_ref(t);
        check(req, t, exp_ref(r));
    endtask

    always @(posedge clk_vco) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000", cycles);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk_vco);
        check("R5 fb low in reset", int'(fb_pulse), 0);
        check("R7 ref low in reset", int'(ref_pulse), 0);
        rst_n = 1'b1;
        // R6: strap 0 default ratio, then programmed ratio
        wait_fb(t);
        check("R6 strap0 default", t, 3753);
        cur_n = 200;
        @(negedge clk_vco);
        check("R5 fb one cycle", int'(fb_pulse), 0);
        wait_fb(t);
        check("R1 programmed ratio", t + 1, exp_ratio(200));

        for (int i = 0; i < 8; i++) begin
            int n;
            n = 56 + int'($urandom_range(0, 1991));
            program_n("R2 random ratio", n);
        end
        program_n("R3 minimum", 56);
        program_n("R2 A7 M7", 63);
        program_n("R3 below minimum", 10);
        program_n("R3 zero", 0);
        program_n("R3 maximum", 8191);
        program_n("R1 A0", 1024);

        // R4: change in the middle of a running period
        n_cfg = 13'd300;
        wait_fb(t);
        check("R4 old ratio kept", t, exp_ratio(cur_n));
        repeat (100) @(negedge clk_vco);
        n_cfg = 13'd500;
        wait_fb(t);
        check("R4 mid-period write ignored", t + 100, 300);
        wait_fb(t);
        check("R4 new ratio after boundary", t, 500);

        // R6: strap 1 default ratio
        @(negedge clk_vco);
        rst_n = 1'b0;
        strap_alt = 1'b1;
        r_cfg = 10'd0;
        @(negedge clk_vco);
        check("R5 fb low in reset", int'(fb_pulse), 0);
        @(negedge clk_vco);
        rst_n = 1'b1;
        wait_fb(t);
        check("R6 strap1 default", t, 3695);

        // Reference divider
        cur_r = 0;
        wait_ref(t);
        check("R8 divide by one after reset", t, 1);
        wait_ref(t);
        check("R8 zero means one", t, 1);
        program_r("R7 ratio 2", 2);
        program_r("R7 ratio 1", 1);
        program_r("R7 ratio 5", 5);
        program_r("R9 ratio 3", 3);
        program_r("R7 ratio 1023", 1023);
        program_r("R8 zero", 0);
        for (int i = 0; i < 4; i++) begin
            int r;
            r = int'($urandom_range(1, 300));
            program_r("R7 random ratio", r);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule